// File: doc/BRIEF.md
# Port-mapped pixel plot interface

This block is the console-side I/O port logic of a small game machine. A CPU reaches it through four 8-bit I/O ports at addresses 0, 1, 4 and 5, using a simple request/ready bus. Each port means one thing when it is written and another when it is read.

Writes build up a pixel. Port 4 sets the horizontal coordinate and a video-select flag. Port 5 sets the vertical coordinate and two tone-enable outputs. Port 1 sets a two-bit color. A strobe bit in port 0 then commits the pixel as a single one-clock write request to video RAM. Reads return the console buttons on port 0 and the switches of the two hand controllers on ports 1 and 4. A mute bit in port 0 cuts the controllers off the read path while a plot is under way. Raw button and controller lines pass through a two-flop synchronizer before the read mux.

A three-state bus machine sets the access timing. `ST_IDLE` goes to `ST_ACK` on a request to a fast port (0, 1 or any unmapped address), or to `ST_WAIT` on a request to a slow port (4 or 5). `ST_WAIT` always moves on to `ST_ACK`. `ST_ACK` always returns to `ST_IDLE`. The access takes effect on the edge that enters `ST_ACK`, and `io_ready` is high for the whole `ST_ACK` cycle. The requester holds the address, data and strobes until the edge that ends the ready cycle.

Top module: `pixport_top`

## Requirements
- R1: While reset is held and right after it, io_ready, io_rdata, vram_we, vram_addr, vram_color, tone_en and vid_sel are all 0, and every latched field is 0.
- R2: A read of port 0 returns the synchronized buttons in bit 0 (TIME), bit 1 (MODE), bit 2 (HOLD) and bit 3 (START). Bits 7:4 read as 0.
- R3: With mute clear, a read of port 1 returns the right controller and a read of port 4 returns the left controller. Both use the order bit 0 right, 1 left, 2 back, 3 forward, 4 counter-clockwise, 5 clockwise, 6 pull, 7 push. A read of port 5 returns 0.
- R4: Port 0 write bit 6 is the mute flag. While it is 1, reads of ports 1 and 4 return 0. Port 0 reads are not affected.
- R5: Raw button and controller lines reach the read path through two flops. A read accepted on the same edge as a raw change returns the old value. A read accepted two or more edges later returns the new value.
- R6: Port 0 write bit 5 is the plot strobe. When it goes from 0 to 1, vram_we is high for exactly one clock, in the cycle after the ready cycle of that write. Writing 1 while it is already 1 gives no pulse.
- R7: With each pulse, vram_addr = {Y, X} (Y in bits 11:6, X in bits 5:0) and vram_color = color, taken from the fields latched before the pulse. Both outputs then hold until the next pulse.
- R8: A port 4 write latches bit 0 into vid_sel and bits 6:1 as X, and bit 7 is ignored. A port 5 write latches bits 5:0 as Y, bit 6 into tone_en[0] and bit 7 into tone_en[1]. A port 1 write latches bits 7:6 as the color.
- R9: io_ready is a one-cycle pulse. For ports 0, 1 and unmapped addresses it rises one clock after the request is first sampled in idle. For ports 4 and 5 it rises two clocks after. io_rdata is 0 whenever io_ready is low.
- R10: An access to any address other than 0, 1, 4 or 5 is acknowledged as a fast access, returns 0 and changes no latched field or output.
- R11: If io_wr and io_rd are both high, the access is a write, and io_rdata is 0 in its ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Port address of the current request |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write request, held until the ready cycle ends |
| io_rd | input | 1 | Read request, held until the ready cycle ends |
| io_rdata | output | 8 | Read data, valid while io_ready is high |
| io_ready | output | 1 | One-cycle access acknowledge |
| btn_raw | input | 4 | Console buttons, active high (TIME, MODE, HOLD, START from bit 0) |
| pad_r_raw | input | 8 | Right controller switches, active high |
| pad_l_raw | input | 8 | Left controller switches, active high |
| vram_we | output | 1 | One-clock video RAM write request |
| vram_addr | output | 12 | Pixel address {Y, X} |
| vram_color | output | 2 | Pixel color |
| vid_sel | output | 1 | Latched video-select flag |
| tone_en | output | 2 | Latched tone enables |

## Verification
Two things can land on the same clock edge.

The first is the edge that ends a VRAM write pulse, which is also the edge that accepts the next back-to-back bus request. The bench issues a strobe write and then, with no gap, a write of a new color. It checks that the pulse carries the color latched before the strobe and that vram_color holds that value after the new write commits.

The second is a raw controller change that arrives on the very edge where a read is captured. The bench changes a controller input on the same half-cycle that it starts a port 1 read. It expects the old value from that read and the new value from the read after it.

A behavioural model in the bench predicts every output on every clock and catches any drift at either collision.

// File: rtl/pixport_pkg.sv
package pixport_pkg;
    localparam int PORT_W  = 8;
    localparam int COORD_W = 6;
    localparam int COLOR_W = 2;
    localparam int TONE_W  = 2;
    localparam int BTN_W   = 4;
    localparam int PAD_W   = 8;
    localparam int VADDR_W = 2 * COORD_W;
    localparam int IN_W    = BTN_W + 2 * PAD_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic               mute;
        logic               strobe;
        logic               vsel;
        logic [COLOR_W-1:0] color;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [TONE_W-1:0]  tone;
    } plot_regs_t;
endpackage

// File: rtl/pixport_sync.sv
module pixport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pixport_bus_fsm.sv
module pixport_bus_fsm
    import pixport_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] P_LPAD = 4,
    parameter logic [ADDR_W-1:0] P_VERT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              commit,
    output logic              ready
);
    bus_state_e state, nxt;
    logic req, slow;

    assign req  = io_wr | io_rd;
    assign slow = (io_addr == P_LPAD) || (io_addr == P_VERT);

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req) nxt = slow ? ST_WAIT : ST_ACK;
            ST_WAIT: nxt = ST_ACK;
            ST_ACK:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        ready  = 1'b0;
        unique case (state)
            ST_IDLE: commit = req & ~slow;
            ST_WAIT: commit = 1'b1;
            ST_ACK:  ready  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pixport_regs.sv
module pixport_regs
    import pixport_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] P_CTRL = 0,
    parameter logic [ADDR_W-1:0] P_RPAD = 1,
    parameter logic [ADDR_W-1:0] P_LPAD = 4,
    parameter logic [ADDR_W-1:0] P_VERT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              ready,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [PORT_W-1:0] io_wdata,
    input  logic [BTN_W-1:0]  btn,
    input  logic [PAD_W-1:0]  pad_r,
    input  logic [PAD_W-1:0]  pad_l,
    output plot_regs_t        regs,
    output logic [PORT_W-1:0] io_rdata
);
    logic [PORT_W-1:0] rd_mux;
    logic [PORT_W-1:0] rdata_q;

    always_comb begin
        case (io_addr)
            P_CTRL:  rd_mux = {{(PORT_W-BTN_W){1'b0}}, btn};
            P_RPAD:  rd_mux = regs.mute ? '0 : pad_r;
            P_LPAD:  rd_mux = regs.mute ? '0 : pad_l;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs    <= '0;
            rdata_q <= '0;
        end else if (commit) begin
            if (io_wr) begin
                rdata_q <= '0;
                if (io_addr == P_CTRL) begin
                    regs.mute   <= io_wdata[6];
                    regs.strobe <= io_wdata[5];
                end
                if (io_addr == P_RPAD) begin
                    regs.color <= io_wdata[7:6];
                end
                if (io_addr == P_LPAD) begin
                    regs.vsel <= io_wdata[0];
                    regs.x    <= io_wdata[COORD_W:1];
                end
                if (io_addr == P_VERT) begin
                    regs.y    <= io_wdata[COORD_W-1:0];
                    regs.tone <= io_wdata[7:6];
                end
            end else if (io_rd) begin
                rdata_q <= rd_mux;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign io_rdata = ready ? rdata_q : '0;
endmodule

// File: rtl/pixport_plot.sv
module pixport_plot
    import pixport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  plot_regs_t         regs,
    output logic               vram_we,
    output logic [VADDR_W-1:0] vram_addr,
    output logic [COLOR_W-1:0] vram_color
);
    logic strobe_prev;
    logic fire;

    assign fire = regs.strobe & ~strobe_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
            vram_we     <= 1'b0;
            vram_addr   <= '0;
            vram_color  <= '0;
        end else begin
            strobe_prev <= regs.strobe;
            vram_we     <= fire;
            if (fire) begin
                vram_addr  <= {regs.y, regs.x};
                vram_color <= regs.color;
            end
        end
    end
endmodule

// File: rtl/pixport_top.sv
module pixport_top
    import pixport_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] P_CTRL      = 0,
    parameter logic [ADDR_W-1:0] P_RPAD      = 1,
    parameter logic [ADDR_W-1:0] P_LPAD      = 4,
    parameter logic [ADDR_W-1:0] P_VERT      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [PORT_W-1:0]  io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [PORT_W-1:0]  io_rdata,
    output logic               io_ready,
    input  logic [BTN_W-1:0]   btn_raw,
    input  logic [PAD_W-1:0]   pad_r_raw,
    input  logic [PAD_W-1:0]   pad_l_raw,
    output logic               vram_we,
    output logic [VADDR_W-1:0] vram_addr,
    output logic [COLOR_W-1:0] vram_color,
    output logic               vid_sel,
    output logic [TONE_W-1:0]  tone_en
);
    logic [IN_W-1:0] in_sync;
    logic            commit;
    plot_regs_t      regs;

    pixport_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pad_l_raw, pad_r_raw, btn_raw}),
        .q     (in_sync)
    );

    pixport_bus_fsm #(.ADDR_W(ADDR_W), .P_LPAD(P_LPAD), .P_VERT(P_VERT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .commit  (commit),
        .ready   (io_ready)
    );

    pixport_regs #(
        .ADDR_W(ADDR_W), .P_CTRL(P_CTRL), .P_RPAD(P_RPAD),
        .P_LPAD(P_LPAD), .P_VERT(P_VERT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .ready    (io_ready),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .btn      (in_sync[BTN_W-1:0]),
        .pad_r    (in_sync[BTN_W+PAD_W-1:BTN_W]),
        .pad_l    (in_sync[IN_W-1:BTN_W+PAD_W]),
        .regs     (regs),
        .io_rdata (io_rdata)
    );

    pixport_plot u_plot (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs       (regs),
        .vram_we    (vram_we),
        .vram_addr  (vram_addr),
        .vram_color (vram_color)
    );

    assign vid_sel = regs.vsel;
    assign tone_en = regs.tone;
endmodule

// File: rtl/pixport_chk.sv
module pixport_chk
    import pixport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [PORT_W-1:0] io_wdata,
    input logic              io_wr,
    input logic              io_rd,
    input logic [PORT_W-1:0] io_rdata,
    input logic              io_ready,
    input logic              vram_we,
    input logic [TONE_W-1:0] tone_en
);
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready);

    p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ready |-> io_rdata == '0);

    p_slow_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(io_ready) && (io_addr == 4 || io_addr == 5)) |-> $past(io_rd || io_wr, 2));

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |=> !vram_we);

    p_we_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> $past(io_ready && io_wr && io_addr == 0 && io_wdata[5]));

    // R10 and R11: no read source, or a write, gives zero data
    p_nosrc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ready && (io_wr || !(io_addr == 0 || io_addr == 1 || io_addr == 4))) |-> io_rdata == '0);

    p_port0_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ready && io_rd && !io_wr && io_addr == 0) |-> io_rdata[7:4] == 4'd0);

    p_tone_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tone_en) |-> (io_ready && io_wr && io_addr == 5));
endmodule

bind pixport_top pixport_chk #(.ADDR_W(ADDR_W)) i_pixport_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .io_ready (io_ready),
    .vram_we  (vram_we),
    .tone_en  (tone_en)
);

// File: tb/test_pixport_top.sv
module test_pixport_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  io_addr, io_wdata, io_rdata;
    logic        io_wr, io_rd, io_ready;
    logic [3:0]  btn_raw;
    logic [7:0]  pad_r_raw, pad_l_raw;
    logic        vram_we, vid_sel;
    logic [11:0] vram_addr;
    logic [1:0]  vram_color, tone_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixport_top i_pixport_top (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_ready(io_ready),
        .btn_raw(btn_raw), .pad_r_raw(pad_r_raw), .pad_l_raw(pad_l_raw),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_color(vram_color),
        .vid_sel(vid_sel), .tone_en(tone_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int          m_st;
    logic [7:0]  m_rdq;
    logic        m_mute, m_strobe, m_prev, m_vsel, m_we;
    logic [1:0]  m_col, m_tone, m_ocol;
    logic [5:0]  m_x, m_y;
    logic [11:0] m_oaddr;
    logic [19:0] m_s1, m_s2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_rdq = 0; m_mute = 0; m_strobe = 0; m_prev = 0;
            m_vsel = 0; m_we = 0; m_col = 0; m_tone = 0; m_ocol = 0;
            m_x = 0; m_y = 0; m_oaddr = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            automatic bit req = io_wr | io_rd;
            automatic bit slow = (io_addr == 8'd4) || (io_addr == 8'd5);
            automatic bit take = (m_st == 0 && req && !slow) || (m_st == 1);
            automatic logic [7:0] rv = 8'd0;
            if (io_addr == 8'd0) rv = {4'd0, m_s2[3:0]};
            else if (io_addr == 8'd1) rv = m_mute ? 8'd0 : m_s2[11:4];
            else if (io_addr == 8'd4) rv = m_mute ? 8'd0 : m_s2[19:12];
            m_we = m_strobe & ~m_prev;
            if (m_we) begin m_oaddr = {m_y, m_x}; m_ocol = m_col; end
            m_prev = m_strobe;
            if (take) begin
                if (io_wr) begin
                    m_rdq = 0;
                    case (io_addr)
                        8'd0: begin m_mute = io_wdata[6]; m_strobe = io_wdata[5]; end
                        8'd1: m_col = io_wdata[7:6];
                        8'd4: begin m_vsel = io_wdata[0]; m_x = io_wdata[6:1]; end
                        8'd5: begin m_y = io_wdata[5:0]; m_tone = io_wdata[7:6]; end
                        default: ;
                    endcase
                end else if (io_rd) m_rdq = rv;
                else m_rdq = 0;
            end
            if (m_st == 0) m_st = req ? (slow ? 1 : 2) : 0;
            else if (m_st == 1) m_st = 2;
            else m_st = 0;
            m_s2 = m_s1;
            m_s1 = {pad_l_raw, pad_r_raw, btn_raw};
        end
    end

    // per-cycle comparison against the model, away from the active edge
    int pulses = 0;
    logic [11:0] seen_addr;
    logic [1:0]  seen_col;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 ready", io_ready, (m_st == 2));
            check("R3 rdata", io_rdata, (m_st == 2) ? m_rdq : 8'd0);
            check("R6 vram_we", vram_we, m_we);
            check("R7 vram_addr", vram_addr, m_oaddr);
            check("R7 vram_color", vram_color, m_ocol);
            check("R8 tone_en", tone_en, m_tone);
            check("R8 vid_sel", vid_sel, m_vsel);
            if (vram_we) begin
                pulses++;
                seen_addr = vram_addr;
                seen_col  = vram_color;
            end
        end
    end

    task automatic acc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d,
                       output logic [7:0] q, output int lat);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d; lat = 0;
        do begin @(negedge clk); lat++; end while (!io_ready && lat < 50);
        q = io_rdata;
        @(negedge clk);
        io_wr = 0; io_rd = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int lat, p0;
        rst_n = 0; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
        btn_raw = 0; pad_r_raw = 0; pad_l_raw = 0;
        repeat (3) @(negedge clk);
        check("R1 reset ready", io_ready, 0);
        check("R1 reset rdata", io_rdata, 0);
        check("R1 reset we", vram_we, 0);
        check("R1 reset addr", vram_addr, 0);
        check("R1 reset tone", tone_en, 0);
        check("R1 reset vsel", vid_sel, 0);
        rst_n = 1;
        btn_raw = 4'b1001; pad_r_raw = 8'h5A; pad_l_raw = 8'hC3;
        settle();

        acc(0, 1, 8'd0, 8'h00, q, lat);
        check("R2 port0 buttons", q, 8'h09);
        check("R9 fast latency", lat, 1);
        acc(0, 1, 8'd1, 8'h00, q, lat);
        check("R3 right pad", q, 8'h5A);
        acc(0, 1, 8'd4, 8'h00, q, lat);
        check("R3 left pad", q, 8'hC3);
        check("R9 slow latency", lat, 2);
        acc(0, 1, 8'd5, 8'h00, q, lat);
        check("R3 port5 read", q, 8'h00);

        acc(1, 0, 8'd0, 8'h40, q, lat);
        acc(0, 1, 8'd1, 8'h00, q, lat);
        check("R4 muted right", q, 8'h00);
        acc(0, 1, 8'd4, 8'h00, q, lat);
        check("R4 muted left", q, 8'h00);
        acc(0, 1, 8'd0, 8'h00, q, lat);
        check("R4 buttons unmuted", q, 8'h09);
        acc(1, 0, 8'd0, 8'h00, q, lat);

        acc(1, 0, 8'd4, 8'hCB, q, lat);
        check("R8 vid_sel", vid_sel, 1);
        acc(1, 0, 8'd5, 8'hD5, q, lat);
        check("R8 tone", tone_en, 2'b11);
        acc(1, 0, 8'd1, 8'h80, q, lat);
        p0 = pulses;
        acc(1, 0, 8'd0, 8'h20, q, lat);
        settle();
        check("R6 one pulse", pulses - p0, 1);
        check("R7 pulse addr", seen_addr, 12'h565);
        check("R7 pulse color", seen_col, 2'b10);
        p0 = pulses;
        acc(1, 0, 8'd0, 8'h20, q, lat);
        settle();
        check("R6 no repulse", pulses - p0, 0);

        acc(1, 0, 8'd2, 8'hFF, q, lat);
        check("R10 unmapped latency", lat, 1);
        acc(1, 0, 8'd6, 8'h3F, q, lat);
        acc(0, 1, 8'd2, 8'h00, q, lat);
        check("R10 unmapped read", q, 8'h00);
        check("R10 tone kept", tone_en, 2'b11);
        acc(1, 0, 8'd0, 8'h00, q, lat);
        acc(1, 0, 8'd0, 8'h20, q, lat);
        settle();
        check("R10 addr kept", seen_addr, 12'h565);

        acc(1, 1, 8'd1, 8'h40, q, lat);
        check("R11 write wins rdata", q, 8'h00);
        acc(1, 0, 8'd0, 8'h00, q, lat);
        p0 = pulses;
        acc(1, 0, 8'd0, 8'h20, q, lat);
        acc(1, 0, 8'd1, 8'hC0, q, lat);
        settle();
        check("R11 color from rd+wr", seen_col, 2'b01);
        check("R7 held across collision", vram_color, 2'b01);
        check("R6 collision pulse", pulses - p0, 1);

        io_wr = 0; io_rd = 1; io_addr = 8'd1; pad_r_raw = 8'h3C;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!io_ready && lat < 50);
        check("R5 old value on same edge", io_rdata, 8'h5A);
        @(negedge clk); io_rd = 0;
        acc(0, 1, 8'd1, 8'h00, q, lat);
        check("R5 new value later", q, 8'h3C);

        settle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule